// File: doc/BRIEF.md
# Relaxed Float-to-Int32 Truncation Unit

This block converts a 128-bit vector of floating-point values into 32-bit integers, rounding every lane toward zero. In single-precision mode the vector carries four IEEE-754 binary32 values and four integer lanes come out. In double-precision mode it carries two binary64 values. These fill the two low integer lanes, and the two high lanes are forced to zero. A signedness select chooses between a signed and an unsigned 32-bit target.

Values whose truncated result fits the target come out exactly. NaN and out-of-range lanes have two permitted results each. Two elaboration parameters pick which one the hardware returns: `NAN_ZERO` chooses the NaN result and `OVF_SAT` chooses the overflow side that has a choice. The conversion is combinational and the result is captured in one output register. A result therefore appears one clock after the input strobe.

Top module: `fp_trunc_i32`

## Requirements
- R1: In single mode (`in_dbl`=0), lane i is taken from `in_vec[32i+31:32i]` and written to `out_vec[32i+31:32i]`. A lane whose value truncated toward zero fits the target gives that exact value, e.g. 123.9→123, −5.5→−5 (signed), −0.7→0 (signed).
- R2: Signed mode (`in_unsigned`=0): a NaN lane gives 0 when `NAN_ZERO`=1, otherwise 0x80000000.
- R3: Signed mode: a value whose truncation is below −2^31, including −infinity, gives 0x80000000. Exactly −2^31 converts exactly.
- R4: Signed mode: a value of 2^31 or more, including +infinity, gives 0x7FFFFFFF when `OVF_SAT`=1, otherwise 0x80000000.
- R5: Unsigned mode (`in_unsigned`=1): a NaN lane gives 0 when `NAN_ZERO`=1, otherwise 0xFFFFFFFF.
- R6: Unsigned mode: a value of 2^32 or more, including +infinity, gives 0xFFFFFFFF. Values up to 2^32−1 convert exactly.
- R7: Unsigned mode: a negative value whose truncation is nonzero, including −infinity, gives 0 when `OVF_SAT`=1, otherwise 0xFFFFFFFF. A negative value in (−1, 0] gives 0.
- R8: In double mode (`in_dbl`=1), `in_vec[63:0]` converts into `out_vec[31:0]` and `in_vec[127:64]` into `out_vec[63:32]`, following the same rules as R1–R7. `out_vec[127:64]` is zero.
- R9: Zeros and denormal inputs of either sign convert to 0 in both signedness modes.
- R10: `out_valid` is high exactly one cycle after `in_valid` was high, and carries that input's result. While `in_valid` is low, `out_vec` holds its last value. Synchronous active-low reset clears `out_valid` and `out_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector strobe |
| in_dbl | input | 1 | 1: two binary64 lanes, 0: four binary32 lanes |
| in_unsigned | input | 1 | 1: unsigned 32-bit target, 0: signed |
| in_vec | input | 128 | Packed floating-point lanes |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_vec | output | 128 | Packed 32-bit integer lanes |

## Verification
The hardest cases to reach are the values sitting on the edges of the integer range. These include the single-precision exponent that yields magnitudes in [2^31, 2^32), where −2^31 must stay exact while +2^31 must overflow, and the largest representable values just under each limit. The stimulus reaches them with hand-built bit patterns rather than arithmetic. Examples are 0x4EFFFFFF, 0x4F000000, 0xCF000000 and 0x4F7FFFFF, plus the double 2^31−1 whose mantissa fills exactly 30 bits. Infinities, NaNs, negative fractions and denormals are mixed into the same vectors, so that each lane must be judged on its own.

// File: rtl/fp_trunc_pkg.sv
// Shared constants for the float-to-int32 truncation unit.
// Assumes a 32-bit integer target.
package fp_trunc_pkg;
    localparam int INT_W = 32;
    localparam logic [INT_W-1:0] S_MIN = 32'h8000_0000;
    localparam logic [INT_W-1:0] S_MAX = 32'h7FFF_FFFF;
    localparam logic [INT_W-1:0] U_MAX = 32'hFFFF_FFFF;
    localparam logic [INT_W-1:0] ZERO  = 32'h0000_0000;
endpackage

// File: rtl/trunc_lane.sv
// One combinational float-to-int32 converter for a binary format with
// EW exponent bits and MW mantissa bits. Rounds toward zero and applies
// the NaN / overflow choices given by NAN_ZERO and OVF_SAT.
// Assumes EW >= 7 (so the exponent can reach 2^32) and MW >= 1.
module trunc_lane
    import fp_trunc_pkg::*;
#(
    parameter int EW = 8,
    parameter int MW = 23,
    parameter bit NAN_ZERO = 1'b1,
    parameter bit OVF_SAT = 1'b1
) (
    input  logic [EW+MW:0]    fp,
    input  logic              uns,
    output logic [INT_W-1:0]  res
);
    localparam int FW = EW + MW + 1;
    localparam int SW = MW + INT_W + 1;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW:0] BIAS_X = BIAS[EW:0];
    localparam logic [EW:0] LIM_X = BIAS_X + (EW+1)'(INT_W);
    localparam logic [4:0] BIAS5 = BIAS[4:0];

    logic          sgn;
    logic [EW-1:0] expo;
    logic [MW-1:0] man;
    logic [EW:0]   exp_x;
    logic          is_nan, tiny, big;
    logic [4:0]    shamt;
    logic [SW-1:0] wide;
    logic [INT_W-1:0] mag;
    logic          unused_lo;

    assign sgn   = fp[FW-1];
    assign expo  = fp[FW-2:MW];
    assign man   = fp[MW-1:0];
    assign exp_x = {1'b0, expo};

    // Classify the operand: NaN, below one, or beyond 32 integer bits.
    always_comb begin
        is_nan = (&expo) && (|man);
        tiny   = exp_x < BIAS_X;
        big    = (&expo) || (exp_x >= LIM_X);
    end

    // Align the significand so that the integer part lands in the low 32 bits.
    always_comb begin
        shamt = expo[4:0] - BIAS5;
        wide  = {{INT_W{1'b0}}, 1'b1, man} << shamt;
        mag   = (tiny || big) ? ZERO : wide[MW+INT_W-1:MW];
    end
    assign unused_lo = ^wide[MW-1:0] ^ wide[SW-1];

    // Pick the final integer from the magnitude, sign and special cases.
    always_comb begin
        if (!uns) begin
            if (is_nan)
                res = NAN_ZERO ? ZERO : S_MIN;
            else if (sgn)
                res = (big || mag > S_MIN) ? S_MIN : (ZERO - mag);
            else
                res = (big || mag[INT_W-1]) ? (OVF_SAT ? S_MAX : S_MIN) : mag;
        end else begin
            if (is_nan)
                res = NAN_ZERO ? ZERO : U_MAX;
            else if (sgn)
                res = (!big && mag == ZERO) ? ZERO : (OVF_SAT ? ZERO : U_MAX);
            else
                res = big ? U_MAX : mag;
        end
    end
endmodule

// File: rtl/fp_trunc_i32.sv
// Vector float-to-int32 truncation unit. Converts four binary32 lanes or
// two binary64 lanes (upper result half zeroed) and registers the result
// with one cycle of latency. Assumes VEC_W is a multiple of 64.
module fp_trunc_i32
    import fp_trunc_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter bit NAN_ZERO = 1'b1,
    parameter bit OVF_SAT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_dbl,
    input  logic             in_unsigned,
    input  logic [VEC_W-1:0] in_vec,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);
    localparam int NSP = VEC_W / 32;
    localparam int NDP = VEC_W / 64;
    localparam int DP_OUT_W = NDP * INT_W;

    logic [INT_W-1:0] sp_res [NSP];
    logic [INT_W-1:0] dp_res [NDP];
    logic [VEC_W-1:0] nxt;

    // Single-precision converters, one per 32-bit lane.
    for (genvar i = 0; i < NSP; i++) begin : g_sp
        trunc_lane #(.EW(8), .MW(23), .NAN_ZERO(NAN_ZERO), .OVF_SAT(OVF_SAT)) u_lane (
            .fp (in_vec[32*i +: 32]),
            .uns(in_unsigned),
            .res(sp_res[i])
        );
    end

    // Double-precision converters, one per 64-bit lane.
    for (genvar j = 0; j < NDP; j++) begin : g_dp
        trunc_lane #(.EW(11), .MW(52), .NAN_ZERO(NAN_ZERO), .OVF_SAT(OVF_SAT)) u_lane (
            .fp (in_vec[64*j +: 64]),
            .uns(in_unsigned),
            .res(dp_res[j])
        );
    end

    // Assemble the next output vector for the selected precision.
    always_comb begin
        nxt = '0;
        if (in_dbl) begin
            for (int k = 0; k < NDP; k++) nxt[INT_W*k +: INT_W] = dp_res[k];
        end else begin
            for (int k = 0; k < NSP; k++) nxt[INT_W*k +: INT_W] = sp_res[k];
        end
    end

    // Output register: capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_vec <= nxt;
        end
    end

    logic       l0_nan, l0_neg;
    logic [7:0] l0_exp;
    assign l0_exp = in_vec[30:23];
    assign l0_neg = in_vec[31];
    assign l0_nan = (&l0_exp) && (|in_vec[22:0]);

    assert_nan_signed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dbl && !in_unsigned && l0_nan)
        |=> out_vec[31:0] == (NAN_ZERO ? ZERO : S_MIN));

    assert_pos_ovf_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dbl && !in_unsigned && !l0_neg && !l0_nan && l0_exp >= 8'd158)
        |=> out_vec[31:0] == (OVF_SAT ? S_MAX : S_MIN));

    assert_big_unsigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dbl && in_unsigned && !l0_neg && !l0_nan && l0_exp >= 8'd159)
        |=> out_vec[31:0] == U_MAX);

    assert_dbl_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dbl) |=> out_vec[VEC_W-1:DP_OUT_W] == '0);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_vec)));
endmodule

// File: tb/tb_fp_trunc_i32.sv
`timescale 1ns/1ps
module tb_fp_trunc_i32;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_dbl = 1'b0;
    logic         in_unsigned = 1'b0;
    logic [127:0] in_vec = '0;
    logic         out_valid;
    logic [127:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [127:0] q_exp [$];
    string        q_tag [$];

    always #2.5 clk = ~clk;

    fp_trunc_i32 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_unsigned(in_unsigned), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Driver: present one vector and queue its expected result.
    task automatic drive(input string tag, input bit dbl, input bit uns,
                         input logic [127:0] v, input logic [127:0] e);
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_unsigned = uns; in_vec = v;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare every result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected out_valid actual %h expected none", out_vec);
            end else begin
                check(q_tag.pop_front(), out_vec, q_exp.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", {127'b0, out_valid}, 128'd0);
        check("R10 reset out_vec", out_vec, 128'd0);
        rst_n = 1'b1;

        // R1: in-range single values, signed
        drive("R1 single signed in range", 0, 0,
              {32'h3F800000, 32'hBF333333, 32'h42F7CCCD, 32'hC0B00000},
              {32'd1, 32'd0, 32'd123, 32'hFFFFFFFB});
        // R2 NaN, R3 -2^31 exact and -2^32, R4 +2^31
        drive("R2 R3 R4 signed edges", 0, 0,
              {32'h7FC00000, 32'hCF000000, 32'hCF800000, 32'h4F000000},
              {32'h0, 32'h80000000, 32'h80000000, 32'h7FFFFFFF});
        // R4 +inf, R3 -inf, R1 largest below 2^31, R9 denormal
        drive("R3 R4 R1 R9 infinities and limits", 0, 0,
              {32'h7F800000, 32'hFF800000, 32'h4EFFFFFF, 32'h00000001},
              {32'h7FFFFFFF, 32'h80000000, 32'h7FFFFF80, 32'h0});
        // R6 unsigned large values and exact top range
        drive("R6 unsigned top range", 0, 1,
              {32'h4F000000, 32'h4F7FFFFF, 32'h4F800000, 32'h7F800000},
              {32'h80000000, 32'hFFFFFF00, 32'hFFFFFFFF, 32'hFFFFFFFF});
        // R5 NaN, R7 negatives
        drive("R5 R7 unsigned NaN and negatives", 0, 1,
              {32'hFFC00000, 32'hBF800000, 32'hBF333333, 32'hFF800000},
              {32'h0, 32'h0, 32'h0, 32'h0});
        // R9 zeros and denormals, unsigned
        drive("R9 zeros and denormals", 0, 1,
              {32'h80000000, 32'h00000000, 32'h80400000, 32'h42F7CCCD},
              {32'h0, 32'h0, 32'h0, 32'd123});
        // R8 double signed
        drive("R8 double signed", 1, 0,
              {64'hC00E000000000000, 64'h3FF0000000000000},
              {64'h0, 32'hFFFFFFFD, 32'd1});
        drive("R8 R4 double limits", 1, 0,
              {64'h41E0000000000000, 64'h41DFFFFFFFC00000},
              {64'h0, 32'h7FFFFFFF, 32'h7FFFFFFF});
        drive("R8 R5 R6 double unsigned", 1, 1,
              {64'h41F0000000000000, 64'h7FF8000000000000},
              {64'h0, 32'hFFFFFFFF, 32'h0});

        // R10: idle with changing inputs, output must hold
        @(negedge clk);
        in_valid = 1'b0; in_vec = {4{32'h3F800000}}; in_dbl = 1'b0;
        @(negedge clk);
        held = out_vec;
        repeat (3) begin
            @(negedge clk);
            in_vec = ~in_vec;
            check("R10 idle out_valid low", {127'b0, out_valid}, 128'd0);
            check("R10 idle out_vec held", out_vec, held);
        end
        check("R10 scoreboard drained", 128'(q_exp.size()), 128'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule